// File: doc/BRIEF.md
# Sync-Header Bit-Error-Rate Monitor

This block sits on the receive side of a 64b/66b link, after block alignment. For every received block it looks at the 2-bit synchronization header and decides whether that header is legal. It counts the illegal headers over a fixed measurement window of about 125 µs. When more than sixteen illegal headers arrive in one window, it raises a high bit-error-rate flag.

Counting runs only while the aligner reports block lock. The window length is a parameter given in clock cycles. At the default of 19531 cycles, a 156.25 MHz clock gives 125 µs.

Two 8-bit statistics counters come with the monitor, and each has its own clear input:
- One counts how many times the monitor has entered its high-error state.
- The other counts the cycles in which the downstream decode state machine signals entry into its error state.

Top module: `sh_ber_monitor`

## Requirements
- R1: While `blk_lock_i` is low, no header is counted, and `high_ber_o` stays low whatever headers arrive.
- R2: Header value 2'b01 or 2'b10 is legal. Header value 2'b00 or 2'b11 is illegal. An illegal header is counted only in a cycle where `blk_valid_i` is high.
- R3: `high_ber_o` goes high on the clock edge at which the 17th counted illegal header of the current window is taken. Sixteen illegal headers in one window never raise it.
- R4: A window lasts WINDOW_CYCLES locked cycles, and the first window starts on the first locked edge. The next window starts straight after the last one ends, and the illegal-header count starts again from zero, so errors split across two windows are not added together.
- R5: Once high, `high_ber_o` stays high until the end of a window. At that point it falls only if that window counted sixteen or fewer illegal headers.
- R6: `ber_cnt_o` increases by one on each rising edge of `high_ber_o`. It does not increase for later windows in which the flag stays high.
- R7: A cycle with `blk_lock_i` low clears the window timer and the illegal-header count, and forces `high_ber_o` low.
- R8: When a clear input and an increment of the same counter occur in one cycle, that counter becomes 0.
- R9: Both statistics counters are 8 bits wide and hold at 255 instead of wrapping.
- R10: `err_blk_cnt_o` increases by one for each cycle in which `dec_err_i` is high, and `clr_err_cnt_i` sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | Block strobe qualifying `sync_hdr_i` |
| sync_hdr_i | input | 2 | Synchronization header of the current block |
| blk_lock_i | input | 1 | Block alignment achieved |
| dec_err_i | input | 1 | Decode state machine entered its error state |
| clr_ber_cnt_i | input | 1 | Clears the high-error entry counter |
| clr_err_cnt_i | input | 1 | Clears the errored-block counter |
| high_ber_o | output | 1 | High bit-error-rate status |
| ber_cnt_o | output | 8 | Number of entries into the high-error state |
| err_blk_cnt_o | output | 8 | Number of errored-block indications |

## Verification
Some rules are checked by assertions on every cycle:
- The window timer never passes its last value.
- An unlocked cycle always leaves the flag low and the timer at zero.
- The count stays unchanged in cycles with no counted header.
- The flag holds inside a window.
- Each counter changes only by one step, by a clear, or by holding at saturation, and a clear always wins.
- The entry counter changes only on a rising edge of the flag.

Other behaviour can only be shown by the bench's scenarios:
- The exact 16-versus-17 threshold.
- Errors split across a window boundary are not added together.
- The flag falls only after a clean window.
- Lock loss discards partial counts.
- A clear arrives on the same edge as a new entry.

// File: rtl/sh_ber_pkg.sv
package sh_ber_pkg;

  typedef enum logic [1:0] {
    HDR_ILL_LO = 2'b00,
    HDR_DATA   = 2'b01,
    HDR_CTRL   = 2'b10,
    HDR_ILL_HI = 2'b11
  } sync_hdr_e;

  // Only the two mixed-bit patterns are legal headers.
  function automatic logic hdr_illegal(input logic [1:0] hdr);
    return (hdr == HDR_ILL_LO) || (hdr == HDR_ILL_HI);
  endfunction

endpackage

// File: rtl/sh_ber_window.sv
module sh_ber_window #(
  parameter int WINDOW_CYCLES = 19531,
  parameter int ERR_LIMIT     = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic hit_i,
  output logic high_ber_o,
  output logic enter_o
);

  localparam int TMR_W = $clog2(WINDOW_CYCLES);
  localparam int CNT_W = $clog2(ERR_LIMIT + 2);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WINDOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(ERR_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(ERR_LIMIT);

  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             high_q, high_d, win_end, over;

  always_comb begin
    win_end = (tmr_q == TMR_LAST);
    cnt_nxt = (hit_i && cnt_q != CNT_SAT) ? cnt_q + CNT_W'(1) : cnt_q;
    over    = cnt_nxt > CNT_LIM;
    // set at once on overflow; re-evaluated only at window end
    high_d  = win_end ? over : (high_q | over);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (!lock_i) begin
      tmr_q  <= '0;
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else begin
      tmr_q  <= win_end ? '0 : tmr_q + TMR_W'(1);
      cnt_q  <= win_end ? '0 : cnt_nxt;
      high_q <= high_d;
    end
  end

  assign high_ber_o = high_q;
  assign enter_o    = lock_i & high_d & ~high_q;

  AST_TMR_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= TMR_LAST); // R4
  AST_UNLOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> (!high_q && tmr_q == '0 && cnt_q == '0)); // R7
  AST_CNT_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !hit_i && !win_end) |=> $stable(cnt_q)); // R2
  AST_HIGH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_q && lock_i && !win_end) |=> high_q); // R5

endmodule

// File: rtl/sh_stat_counter.sv
module sh_stat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R8
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX); // R9
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1))); // R9

endmodule

// File: rtl/sh_ber_monitor.sv
module sh_ber_monitor
  import sh_ber_pkg::*;
#(
  parameter int WINDOW_CYCLES = 19531,
  parameter int ERR_LIMIT     = 16,
  parameter int STAT_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_valid_i,
  input  logic [1:0]        sync_hdr_i,
  input  logic              blk_lock_i,
  input  logic              dec_err_i,
  input  logic              clr_ber_cnt_i,
  input  logic              clr_err_cnt_i,
  output logic              high_ber_o,
  output logic [STAT_W-1:0] ber_cnt_o,
  output logic [STAT_W-1:0] err_blk_cnt_o
);

  logic hit, enter;

  assign hit = blk_lock_i & blk_valid_i & hdr_illegal(sync_hdr_i);

  sh_ber_window #(
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .ERR_LIMIT    (ERR_LIMIT)
  ) window_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (blk_lock_i),
    .hit_i     (hit),
    .high_ber_o(high_ber_o),
    .enter_o   (enter)
  );

  sh_stat_counter #(.CNT_W(STAT_W)) ber_cnt_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (enter),
    .clr_i (clr_ber_cnt_i),
    .cnt_o (ber_cnt_o)
  );

  sh_stat_counter #(.CNT_W(STAT_W)) err_cnt_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (dec_err_i),
    .clr_i (clr_err_cnt_i),
    .cnt_o (err_blk_cnt_o)
  );

  localparam logic [STAT_W-1:0] STAT_MAX = {STAT_W{1'b1}};

  AST_ENTRY_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(high_ber_o) && !$past(clr_ber_cnt_i) && $past(ber_cnt_o) != STAT_MAX)
      |-> ber_cnt_o == $past(ber_cnt_o) + STAT_W'(1)); // R6
  AST_ENTRY_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$rose(high_ber_o) && !$past(clr_ber_cnt_i)) |-> ber_cnt_o == $past(ber_cnt_o)); // R6
  AST_NOLOCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_lock_i |=> !high_ber_o); // R1
  AST_ERRBLK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dec_err_i) && !$past(clr_err_cnt_i) && $past(err_blk_cnt_o) != STAT_MAX)
      |-> err_blk_cnt_o == $past(err_blk_cnt_o) + STAT_W'(1)); // R10

endmodule

// File: tb/sh_ber_monitor_tb_top.sv
module sh_ber_monitor_tb_top;

  localparam int W = 64;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       blk_valid = 1'b0;
  logic [1:0] sync_hdr = 2'b01;
  logic       blk_lock = 1'b0;
  logic       dec_err = 1'b0;
  logic       clr_ber = 1'b0;
  logic       clr_err = 1'b0;
  logic       high_ber;
  logic [7:0] ber_cnt, err_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int exp_ent = 0;

  always #10 clk = ~clk;

  sh_ber_monitor #(.WINDOW_CYCLES(W), .ERR_LIMIT(16), .STAT_W(8)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .blk_valid_i  (blk_valid),
    .sync_hdr_i   (sync_hdr),
    .blk_lock_i   (blk_lock),
    .dec_err_i    (dec_err),
    .clr_ber_cnt_i(clr_ber),
    .clr_err_cnt_i(clr_err),
    .high_ber_o   (high_ber),
    .ber_cnt_o    (ber_cnt),
    .err_blk_cnt_o(err_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one block, let one rising edge pass, return at the falling edge
  task automatic cyc(input logic v, input logic [1:0] h);
    blk_valid = v;
    sync_hdr  = h;
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic v, input logic [1:0] h);
    for (int i = 0; i < n; i++) cyc(v, h);
  endtask

  // one unlocked cycle, then lock: the next edge is window cycle 0
  task automatic relock();
    blk_lock = 1'b0;
    cyc(1'b1, 2'b01);
    blk_lock = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 reset high_ber", high_ber, 0);
    chk("R6 reset ber_cnt", ber_cnt, 0);
    chk("R10 reset err_cnt", err_cnt, 0);
  endtask

  task automatic t_no_lock();
    blk_lock = 1'b0;
    run(40, 1'b1, 2'b00);
    chk("R1 unlocked errors ignored", high_ber, 0);
    blk_lock = 1'b1;
    run(W, 1'b1, 2'b01);
    chk("R1 no carry into locked window", high_ber, 0);
    chk("R1 entry count untouched", ber_cnt, 0);
  endtask

  task automatic t_headers();
    relock();
    run(20, 1'b1, 2'b01);
    run(20, 1'b1, 2'b10);
    run(20, 1'b0, 2'b11);
    run(4, 1'b0, 2'b00);
    chk("R2 legal or unstrobed headers not counted", high_ber, 0);
  endtask

  task automatic t_threshold();
    relock();
    run(16, 1'b1, 2'b00);
    chk("R3 sixteen errors keep low", high_ber, 0);
    run(W - 16, 1'b1, 2'b01);
    chk("R3 window of sixteen ends low", high_ber, 0);
    run(8, 1'b1, 2'b00);
    run(8, 1'b1, 2'b11);
    chk("R3 sixteen in new window low", high_ber, 0);
    cyc(1'b1, 2'b11);
    exp_ent++;
    chk("R3 seventeenth error raises", high_ber, 1);
    chk("R6 entry counted", ber_cnt, exp_ent);
    run(W - 17, 1'b1, 2'b01);
    chk("R5 high at window end", high_ber, 1);
    run(20, 1'b1, 2'b00);
    run(W - 20, 1'b1, 2'b10);
    chk("R6 stays high, no new entry", ber_cnt, exp_ent);
    chk("R5 bad window keeps high", high_ber, 1);
    run(W - 1, 1'b1, 2'b01);
    chk("R5 held until window end", high_ber, 1);
    cyc(1'b1, 2'b01);
    chk("R5 clean window drops flag", high_ber, 0);
    run(17, 1'b1, 2'b00);
    exp_ent++;
    chk("R6 re-entry counted", ber_cnt, exp_ent);
    run(W - 17, 1'b1, 2'b01);
  endtask

  task automatic t_boundary();
    relock();
    run(W - 10, 1'b1, 2'b01);
    run(10, 1'b1, 2'b00);
    run(10, 1'b1, 2'b11);
    chk("R4 split errors not summed", high_ber, 0);
    run(W - 10, 1'b1, 2'b01);
    chk("R4 second window clean", high_ber, 0);
  endtask

  task automatic t_lock_loss();
    relock();
    run(10, 1'b1, 2'b00);
    relock();
    run(10, 1'b1, 2'b00);
    run(W - 10, 1'b1, 2'b01);
    chk("R7 lock loss discards count", high_ber, 0);
    relock();
    run(17, 1'b1, 2'b00);
    exp_ent++;
    chk("R7 raised before loss", high_ber, 1);
    chk("R6 entry before loss", ber_cnt, exp_ent);
    blk_lock = 1'b0;
    cyc(1'b1, 2'b01);
    chk("R7 lock loss drops flag", high_ber, 0);
  endtask

  task automatic t_clear();
    clr_ber = 1'b1;
    cyc(1'b1, 2'b01);
    clr_ber = 1'b0;
    exp_ent = 0;
    chk("R6 clear entry counter", ber_cnt, 0);
    relock();
    run(16, 1'b1, 2'b00);
    clr_ber = 1'b1;
    cyc(1'b1, 2'b00);
    clr_ber = 1'b0;
    chk("R8 flag rises with clear", high_ber, 1);
    chk("R8 clear beats entry", ber_cnt, 0);
    run(W - 17, 1'b1, 2'b01);
  endtask

  task automatic t_err_cnt();
    dec_err = 1'b1;
    run(5, 1'b1, 2'b01);
    dec_err = 1'b0;
    chk("R10 errored blocks counted", err_cnt, 5);
    cyc(1'b1, 2'b01);
    chk("R10 idle holds", err_cnt, 5);
    dec_err = 1'b1;
    clr_err = 1'b1;
    cyc(1'b1, 2'b01);
    clr_err = 1'b0;
    chk("R8 clear beats increment", err_cnt, 0);
    run(300, 1'b1, 2'b01);
    dec_err = 1'b0;
    chk("R9 saturates at 255", err_cnt, 255);
    clr_err = 1'b1;
    cyc(1'b1, 2'b01);
    clr_err = 1'b0;
    chk("R10 clear errored count", err_cnt, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_no_lock();
    t_headers();
    t_threshold();
    t_boundary();
    t_lock_loss();
    t_clear();
    t_err_cnt();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule